// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block lets a 16-bit clause-22 management port reach a 32-bit internal register file. It sits after the MDIO bit-level receiver. Each decoded transaction arrives as a one-cycle request that carries a PHY address, a register number, a direction and 16 bits of write data. Transactions to every PHY address except the reserved one go straight through to the downstream PHY port. Read data from that port is returned unchanged.

At the reserved PHY address, 31, the register numbers form a window onto the internal space. Register 31 holds a 10-bit page that supplies internal byte-address bits [15:6]. Registers 0 to 15 select one of the sixteen 32-bit words in that page (byte-address bits [5:2]) and carry the lower data half. Register 16 carries the upper half. Software writes the page, then the low half, then the high half. The internal write happens on the high half. To read, software sets the page, reads the low half, then reads the high half. The low-half read fetches the whole word and holds the upper half in a latch, which the high-half read returns.

The internal bus uses a 14-bit word address (byte address bits [15:2], formed as {page, word select}). It has 32-bit write data, single-cycle write and read strobes, and combinational read data that is sampled in the strobe cycle.

Top module: `mdio_regbridge`

## Requirements
- R1: A request whose PHY address is not 31 raises pt_req in the same cycle and forwards direction, PHY address, register and write data. mg_rdata equals pt_rdata, and neither rb_we nor rb_re is raised.
- R2: A write to PHY 31 register 31 loads the 10-bit page from mg_wdata[9:0]. A read of PHY 31 register 31 returns the page in mg_rdata[9:0], with zeros above it.
- R3: The page is zero after reset and keeps its value until register 31 is written again.
- R4: A write to PHY 31 register 0..15 raises no bus strobe. It latches the low data half and the word address {page, reg[3:0]}.
- R5: A write to PHY 31 register 16 raises rb_we for exactly that cycle. rb_addr is the latched word address and rb_wdata is {mg_wdata, latched low half}. No other request raises rb_we.
- R6: A read of PHY 31 register 0..15 raises rb_re in the same cycle with rb_addr = {page, reg[3:0]}, and mg_rdata = rb_rdata[15:0].
- R7: A read of PHY 31 register 16 returns rb_rdata[31:16] as sampled at the most recent low-half read, and raises no bus strobe.
- R8: PHY 31 registers 17..30 are reserved. Writes to them change neither the page nor any bus output, and reads return zero.
- R9: Rewriting the page between a low-half write and its high-half write does not change the committed address. The address captured at the low-half write is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mg_req | input | 1 | One-cycle decoded management transaction |
| mg_we | input | 1 | 1 = write, 0 = read |
| mg_phy | input | 5 | PHY address |
| mg_reg | input | 5 | Register number |
| mg_wdata | input | 16 | Write data |
| mg_rdata | output | 16 | Read data, valid in the request cycle |
| pt_req | output | 1 | Forwarded request for other PHY addresses |
| pt_we | output | 1 | Forwarded direction |
| pt_phy | output | 5 | Forwarded PHY address |
| pt_reg | output | 5 | Forwarded register number |
| pt_wdata | output | 16 | Forwarded write data |
| pt_rdata | input | 16 | Read data from the forwarded target |
| rb_addr | output | 14 | Internal word address {page, word select} |
| rb_wdata | output | 32 | Internal write data {high, low} |
| rb_we | output | 1 | Internal write strobe |
| rb_re | output | 1 | Internal read strobe |
| rb_rdata | input | 32 | Internal read data, sampled in the rb_re cycle |

## Verification
The strobes, forwarded fields and read data are combinational in the request cycle. The bench drives each request at a falling edge and samples every output two time units later, before the rising edge that ends the request. State changes (page, low-half and address latches, high-half latch) take effect at that rising edge. The bench observes them through the next request: a page read, a high-half write or a high-half read. The bench models the register file as an arithmetic function of the address. This lets it compute every expected read word directly, and it sweeps all sixteen word selects across four pages, including page 0 and the all-ones page.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
  // Classification of one decoded management request
  typedef enum logic [2:0] {
    K_NONE,
    K_PASS,
    K_PAGE,
    K_LO,
    K_HI,
    K_RSVD
  } kind_e;
endpackage

// File: rtl/mdb_decode.sv
module mdb_decode
  import mdb_pkg::*;
#(
  parameter int BRIDGE_PHY = 31,
  parameter int PAGE_REG   = 31,
  parameter int HI_REG     = 16,
  parameter int WSEL_W     = 4
) (
  input  logic       req,
  input  logic [4:0] phy,
  input  logic [4:0] regn,
  output kind_e      kind
);
  localparam int LO_CNT = 1 << WSEL_W;

  always_comb begin
    if (!req)                              kind = K_NONE;
    else if (phy != 5'(BRIDGE_PHY))        kind = K_PASS;
    else if (regn == 5'(PAGE_REG))         kind = K_PAGE;
    else if (regn < 5'(LO_CNT))            kind = K_LO;
    else if (regn == 5'(HI_REG))           kind = K_HI;
    else                                   kind = K_RSVD;
  end
endmodule

// File: rtl/mdb_page_reg.sv
module mdb_page_reg #(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [PAGE_W-1:0] d,
  output logic [PAGE_W-1:0] q
);
  logic [PAGE_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/mdb_stage.sv
module mdb_stage #(
  parameter int AW     = 14,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic [AW-1:0]     wr_addr,
  input  logic [HALF_W-1:0] wr_lo,
  input  logic              rd_cap,
  input  logic [HALF_W-1:0] rd_hi,
  output logic [AW-1:0]     addr_q,
  output logic [HALF_W-1:0] lo_q,
  output logic [HALF_W-1:0] hi_q
);
  logic [AW-1:0]     addr_nxt;
  logic [HALF_W-1:0] lo_nxt;
  logic [HALF_W-1:0] hi_nxt;

  always_comb begin
    addr_nxt = addr_q;
    lo_nxt   = lo_q;
    hi_nxt   = hi_q;
    if (lo_wr) begin
      addr_nxt = wr_addr;
      lo_nxt   = wr_lo;
    end
    if (rd_cap) hi_nxt = rd_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      addr_q <= addr_nxt;
      lo_q   <= lo_nxt;
      hi_q   <= hi_nxt;
    end
  end
endmodule

// File: rtl/mdio_regbridge.sv
module mdio_regbridge
  import mdb_pkg::*;
#(
  parameter int BRIDGE_PHY = 31,
  parameter int PAGE_REG   = 31,
  parameter int HI_REG     = 16,
  parameter int PAGE_W     = 10,
  parameter int WSEL_W     = 4,
  parameter int HALF_W     = 16,
  localparam int AW        = PAGE_W + WSEL_W,
  localparam int DW        = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mg_req,
  input  logic              mg_we,
  input  logic [4:0]        mg_phy,
  input  logic [4:0]        mg_reg,
  input  logic [HALF_W-1:0] mg_wdata,
  output logic [HALF_W-1:0] mg_rdata,
  output logic              pt_req,
  output logic              pt_we,
  output logic [4:0]        pt_phy,
  output logic [4:0]        pt_reg,
  output logic [HALF_W-1:0] pt_wdata,
  input  logic [HALF_W-1:0] pt_rdata,
  output logic [AW-1:0]     rb_addr,
  output logic [DW-1:0]     rb_wdata,
  output logic              rb_we,
  output logic              rb_re,
  input  logic [DW-1:0]     rb_rdata
);
  kind_e             kind;
  logic [PAGE_W-1:0] page_q;
  logic [AW-1:0]     addr_q;
  logic [HALF_W-1:0] lo_q;
  logic [HALF_W-1:0] hi_q;
  logic [AW-1:0]     live_addr;
  logic              page_ld;
  logic              lo_wr;

  mdb_decode #(
    .BRIDGE_PHY(BRIDGE_PHY), .PAGE_REG(PAGE_REG),
    .HI_REG(HI_REG), .WSEL_W(WSEL_W)
  ) u_dec (
    .req(mg_req), .phy(mg_phy), .regn(mg_reg), .kind(kind)
  );

  assign page_ld   = (kind == K_PAGE) && mg_we;
  assign lo_wr     = (kind == K_LO) && mg_we;
  assign live_addr = {page_q, mg_reg[WSEL_W-1:0]};

  mdb_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .ld(page_ld),
    .d(mg_wdata[PAGE_W-1:0]), .q(page_q)
  );

  mdb_stage #(.AW(AW), .HALF_W(HALF_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .lo_wr(lo_wr), .wr_addr(live_addr), .wr_lo(mg_wdata),
    .rd_cap(rb_re), .rd_hi(rb_rdata[DW-1:HALF_W]),
    .addr_q(addr_q), .lo_q(lo_q), .hi_q(hi_q)
  );

  // Forwarding path for every other PHY address
  assign pt_req   = (kind == K_PASS);
  assign pt_we    = mg_we;
  assign pt_phy   = mg_phy;
  assign pt_reg   = mg_reg;
  assign pt_wdata = mg_wdata;

  // Internal bus
  assign rb_we    = (kind == K_HI) && mg_we;
  assign rb_re    = (kind == K_LO) && !mg_we;
  assign rb_addr  = rb_we ? addr_q : live_addr;
  assign rb_wdata = {mg_wdata, lo_q};

  always_comb begin
    unique case (kind)
      K_PASS:  mg_rdata = pt_rdata;
      K_PAGE:  mg_rdata = HALF_W'(page_q);
      K_LO:    mg_rdata = rb_rdata[HALF_W-1:0];
      K_HI:    mg_rdata = hi_q;
      default: mg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdb_chk.sv
module mdb_chk #(
  parameter int BRIDGE_PHY = 31,
  parameter int PAGE_REG   = 31,
  parameter int HI_REG     = 16,
  parameter int PAGE_W     = 10,
  parameter int HALF_W     = 16,
  parameter int WSEL_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mg_req,
  input logic              mg_we,
  input logic [4:0]        mg_phy,
  input logic [4:0]        mg_reg,
  input logic              pt_req,
  input logic              rb_we,
  input logic              rb_re,
  input logic [PAGE_W-1:0] page_q,
  input logic [HALF_W-1:0] hi_q
);
  localparam int LO_CNT = 1 << WSEL_W;

  logic at_bridge;
  assign at_bridge = mg_req && (mg_phy == 5'(BRIDGE_PHY));

  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_req && mg_phy != 5'(BRIDGE_PHY)) |-> (pt_req && !rb_we && !rb_re));

  p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_bridge && mg_we && mg_reg == 5'(PAGE_REG)) |=> $stable(page_q));

  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rb_we |-> (at_bridge && mg_we && mg_reg == 5'(HI_REG)));

  p_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rb_re |-> (at_bridge && !mg_we && mg_reg < 5'(LO_CNT)));

  p_hi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_re |=> $stable(hi_q));

  p_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_bridge && mg_reg > 5'(HI_REG) && mg_reg != 5'(PAGE_REG))
      |-> (!rb_we && !rb_re && !pt_req));
endmodule

bind mdio_regbridge mdb_chk #(
  .BRIDGE_PHY(BRIDGE_PHY), .PAGE_REG(PAGE_REG), .HI_REG(HI_REG),
  .PAGE_W(PAGE_W), .HALF_W(HALF_W), .WSEL_W(WSEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mg_req(mg_req), .mg_we(mg_we),
  .mg_phy(mg_phy), .mg_reg(mg_reg), .pt_req(pt_req),
  .rb_we(rb_we), .rb_re(rb_re), .page_q(page_q), .hi_q(hi_q)
);

// File: tb/sim_mdio_regbridge.sv
module sim_mdio_regbridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mg_req = 1'b0;
  logic        mg_we = 1'b0;
  logic [4:0]  mg_phy = '0;
  logic [4:0]  mg_reg = '0;
  logic [15:0] mg_wdata = '0;
  logic [15:0] mg_rdata;
  logic        pt_req, pt_we;
  logic [4:0]  pt_phy, pt_reg;
  logic [15:0] pt_wdata, pt_rdata;
  logic [13:0] rb_addr;
  logic [31:0] rb_wdata, rb_rdata;
  logic        rb_we, rb_re;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] model(input logic [13:0] a);
    return {18'h0, a} * 32'h0009_E377 + 32'h1357_2468;
  endfunction

  assign rb_rdata = model(rb_addr);
  assign pt_rdata = 16'hBEEF ^ {6'h0, pt_phy, pt_reg};

  mdio_regbridge u0 (
    .clk(clk), .rst_n(rst_n), .mg_req(mg_req), .mg_we(mg_we),
    .mg_phy(mg_phy), .mg_reg(mg_reg), .mg_wdata(mg_wdata),
    .mg_rdata(mg_rdata), .pt_req(pt_req), .pt_we(pt_we),
    .pt_phy(pt_phy), .pt_reg(pt_reg), .pt_wdata(pt_wdata),
    .pt_rdata(pt_rdata), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
    .rb_we(rb_we), .rb_re(rb_re), .rb_rdata(rb_rdata)
  );

  // Samples taken inside the request cycle
  logic [15:0] s_rdata;
  logic [13:0] s_addr;
  logic [31:0] s_wdata;
  logic        s_we, s_re, s_pt;
  logic [4:0]  s_ptphy, s_ptreg;
  logic [15:0] s_ptwd;
  logic        s_ptwe;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic we, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] wd);
    @(negedge clk);
    mg_req = 1'b1; mg_we = we; mg_phy = phy; mg_reg = rg; mg_wdata = wd;
    #2;
    s_rdata = mg_rdata; s_addr = rb_addr; s_wdata = rb_wdata;
    s_we = rb_we; s_re = rb_re; s_pt = pt_req;
    s_ptphy = pt_phy; s_ptreg = pt_reg; s_ptwd = pt_wdata; s_ptwe = pt_we;
    @(posedge clk);
    #1 mg_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0]  pages [4];
    logic [15:0] lo, hi;
    logic [31:0] w;
    pages[0] = 10'h000; pages[1] = 10'h001; pages[2] = 10'h155; pages[3] = 10'h3FF;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R3: page after reset is zero
    xact(1'b0, 5'd31, 5'd31, 16'h0);
    check("R3 reset page", {16'h0, s_rdata}, 32'h0);
    check("R3 reset no strobes", {30'h0, s_we, s_re}, 32'h0);

    // R1: pass-through write and read
    xact(1'b1, 5'd5, 5'd9, 16'hA1B2);
    check("R1 pt_req", {31'h0, s_pt}, 32'h1);
    check("R1 fields", {s_ptwe, s_ptphy, s_ptreg, s_ptwd}, {1'b1, 5'd5, 5'd9, 16'hA1B2});
    check("R1 no bus", {30'h0, s_we, s_re}, 32'h0);
    xact(1'b0, 5'd0, 5'd16, 16'h0);
    check("R1 read data", {16'h0, s_rdata}, {16'h0, 16'hBEEF ^ {6'h0, 5'd0, 5'd16}});
    check("R1 no bus rd", {29'h0, s_pt, s_we, s_re}, 32'h4);
    xact(1'b0, 5'd30, 5'd31, 16'h0);
    check("R1 page reg elsewhere", {16'h0, s_rdata}, {16'h0, 16'hBEEF ^ {6'h0, 5'd30, 5'd31}});

    // R2: page write/readback, upper bits ignored
    xact(1'b1, 5'd31, 5'd31, 16'hFE55);
    xact(1'b0, 5'd31, 5'd31, 16'h0);
    check("R2 page readback", {16'h0, s_rdata}, 32'h0000_0255);

    // R8: reserved registers
    for (int r = 17; r <= 30; r++) begin
      xact(1'b1, 5'd31, 5'(r), 16'hFFFF);
      check("R8 rsvd write no strobe", {29'h0, s_pt, s_we, s_re}, 32'h0);
      xact(1'b0, 5'd31, 5'(r), 16'h0);
      check("R8 rsvd read zero", {13'h0, s_pt, s_we, s_re, s_rdata}, 32'h0);
    end
    xact(1'b0, 5'd31, 5'd31, 16'h0);
    check("R8 page untouched", {16'h0, s_rdata}, 32'h0000_0255);

    // Sweep: four pages x sixteen word selects
    for (int p = 0; p < 4; p++) begin
      xact(1'b1, 5'd31, 5'd31, {6'h0, pages[p]});
      xact(1'b0, 5'd31, 5'd31, 16'h0);
      check("R3 page held", {16'h0, s_rdata}, {22'h0, pages[p]});
      for (int ws = 0; ws < 16; ws++) begin
        lo = 16'(pages[p] * 17 + ws * 16'h0301);
        hi = ~lo ^ 16'h5A00;
        xact(1'b1, 5'd31, 5'(ws), lo);
        check("R4 low write no strobe", {29'h0, s_pt, s_we, s_re}, 32'h0);
        xact(1'b1, 5'd31, 5'd16, hi);
        check("R5 commit strobe", {30'h0, s_we, s_re}, 32'h2);
        check("R5 commit addr", {18'h0, s_addr}, {18'h0, pages[p], 4'(ws)});
        check("R5 commit data", s_wdata, {hi, lo});
        w = model({pages[p], 4'(ws)});
        xact(1'b0, 5'd31, 5'(ws), 16'h0);
        check("R6 fetch strobe", {30'h0, s_we, s_re}, 32'h1);
        check("R6 fetch addr", {18'h0, s_addr}, {18'h0, pages[p], 4'(ws)});
        check("R6 low data", {16'h0, s_rdata}, {16'h0, w[15:0]});
        xact(1'b0, 5'd31, 5'd16, 16'h0);
        check("R7 high data", {16'h0, s_rdata}, {16'h0, w[31:16]});
        check("R7 no strobe", {30'h0, s_we, s_re}, 32'h0);
      end
    end

    // R7: high latch survives unrelated traffic
    xact(1'b0, 5'd31, 5'd3, 16'h0);
    w = model({10'h3FF, 4'd3});
    xact(1'b1, 5'd31, 5'd31, 16'h0042);
    xact(1'b1, 5'd7, 5'd16, 16'h1111);
    xact(1'b0, 5'd31, 5'd16, 16'h0);
    check("R7 latch held", {16'h0, s_rdata}, {16'h0, w[31:16]});

    // R9: page change between halves
    xact(1'b1, 5'd31, 5'd31, 16'h0123);
    xact(1'b1, 5'd31, 5'd9, 16'hC0DE);
    xact(1'b1, 5'd31, 5'd31, 16'h0321);
    xact(1'b1, 5'd31, 5'd16, 16'hFACE);
    check("R9 addr from low write", {18'h0, s_addr}, {18'h0, 10'h123, 4'd9});
    check("R9 data", s_wdata, 32'hFACE_C0DE);
    xact(1'b0, 5'd31, 5'd31, 16'h0);
    check("R9 new page kept", {16'h0, s_rdata}, 32'h0000_0321);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule